// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers every reason the chip may need a reset into one internal reset line and keeps that line asserted until the chip is ready to run. There are four reset requests: a power-on indication, an active-low external reset pin, a watchdog request and a brownout condition. The brownout condition comes from the block's own supply monitor. That monitor watches a digitized supply-voltage code in millivolts with two thresholds, each with hysteresis. Crossing the upper threshold only raises a low-voltage flag, which software can read at any time and which reaches the interrupt output when an enable bit is set. Crossing the lower threshold forces a reset.

After the last request drops, a wake-up counter runs for a fixed number of clocks. The internal reset is released only when four things hold together: no request is active, the counter has finished, the oscillator reports ready and the flash reports its initialization done. If a request returns while the counter runs, the counter starts again from zero. A sticky cause register records which requests were seen, and software clears its bits by writing ones. The boot fetch address presented to the processor is a fixed vector that defaults to zero.

Top module: `rstseq_top`

## Requirements
- R1: A low level on `ext_rst_n_i` asserts `rst_o` without waiting for a clock edge. Its release passes through a two-flop synchronizer, so `rst_o` falls on the (WAKE_CLKS+3)-th rising edge counted from the first edge after the pin goes high, with the other conditions met.
- R2: While any of `por_i`, `wdt_req_i`, the external pin or the brownout flag is active, `rst_o` is 1.
- R3: `rst_o` falls only when no request is active, `osc_ready_i` and `flash_done_i` are both 1, and WAKE_CLKS clocks have been counted since the requests ended. For a watchdog or power-on request this is the (WAKE_CLKS+1)-th rising edge after the request is sampled low.
- R4: A request that reasserts while the wake-up counter runs restarts the count from zero, so the full wait applies again after it drops.
- R5: A voltage code below LO_MV (default 2650) sets the brownout flag and asserts `rst_o`. The flag clears only when the code is at or above LO_MV+HYST_MV (default 2700).
- R6: `lv_status_o` sets when the code falls below UP_MV (default 2950) and clears only when the code is at or above UP_MV+HYST_MV (default 3000). This stage never asserts `rst_o` on its own. Each flag follows the code one clock later.
- R7: `lvi_irq_o` equals `lv_status_o` when `lvi_en_i` is 1 and is 0 when `lvi_en_i` is 0.
- R8: If `osc_ready_i` or `flash_done_i` is 0 when the count ends, `rst_o` stays 1. It falls on the first rising edge at which both are sampled 1.
- R9: `cause_o` bit 0 is power-on, bit 1 is the external pin, bit 2 is the watchdog and bit 3 is brownout. A bit is set one clock after its request is active and stays set. A 1 in `cause_clr_i` clears that bit on the next edge unless its request is still active. While `por_i` is high, the register holds only the active requests, which gives 4'b0001 for a plain power-on.
- R10: `boot_addr_o` equals BOOT_ADDR (default 0) at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on request, active high; also the block's synchronous reset |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_req_i | input | 1 | Watchdog reset request, active high |
| vcode_i | input | 12 | Supply voltage code in millivolts |
| osc_ready_i | input | 1 | Oscillator running |
| flash_done_i | input | 1 | Flash initialization finished |
| lvi_en_i | input | 1 | Low-voltage interrupt enable |
| cause_clr_i | input | 4 | Write-one-to-clear strobes for the cause bits |
| rst_o | output | 1 | Internal reset, active high |
| lvi_irq_o | output | 1 | Masked low-voltage interrupt |
| lv_status_o | output | 1 | Raw low-voltage flag |
| cause_o | output | 4 | Sticky reset-cause bits |
| boot_addr_o | output | 32 | First fetch address after reset |

## Verification
The assertions check on every cycle that any active request holds reset on the next cycle, that a request clears the wake-up counter, that a release only follows a cycle with full count, oscillator ready and flash done, and that each monitor flag only changes on the correct side of its trip or hysteresis level. The interrupt masking, the cause bits following their requests, and the pin-low-means-reset rule are also checked on every clock. Only the bench scenarios show the exact release latencies for each request type, the restart after a reasserted request, the wait for a late oscillator or flash, the brownout hold within the hysteresis band, and the write-one clearing of the cause bits.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int VCODE_W = 12;
    localparam int NSRC    = 4;

    typedef logic [VCODE_W-1:0] vcode_t;

    // Request vector: bit 0 power-on, 1 pin, 2 watchdog, 3 brownout
    typedef struct packed {
        logic bod;
        logic wdt;
        logic ext;
        logic por;
    } src_t;

    typedef struct packed {
        logic low_rst;   // lower stage: forces reset
        logic low_irq;   // upper stage: flag and interrupt only
    } vflags_t;

    // One hysteresis comparator step
    function automatic logic hyst_next(input logic   cur,
                                       input vcode_t v,
                                       input vcode_t trip,
                                       input vcode_t margin);
        vcode_t clear_lvl;
        clear_lvl = trip + margin;
        if (cur) return (v < clear_lvl);
        else     return (v < trip);
    endfunction

    function automatic logic any_src(input src_t s);
        return |s;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync (
    input  logic clk,
    input  logic por_i,
    input  logic pin_n_i,
    output logic req_o
);
    logic [1:0] stage_q;

    // Assertion is asynchronous, release passes two flops
    always_ff @(posedge clk or negedge pin_n_i) begin
        if (!pin_n_i) stage_q <= 2'b11;
        else          stage_q <= {stage_q[0], 1'b0};
    end

    assign req_o = stage_q[1];

    AST_PIN_LOW_REQ: assert property (@(posedge clk) disable iff (por_i)
        !pin_n_i |-> req_o); // R1

endmodule

// File: rtl/rstseq_vmon.sv
module rstseq_vmon
    import rstseq_pkg::*;
#(
    parameter int unsigned UP_MV   = 2950,
    parameter int unsigned LO_MV   = 2650,
    parameter int unsigned HYST_MV = 50
) (
    input  logic    clk,
    input  logic    por_i,
    input  vcode_t  vcode_i,
    output vflags_t flags_o
);
    localparam vcode_t MARGIN = vcode_t'(HYST_MV);

    logic [1:0] flag_q;

    for (genvar g = 0; g < 2; g++) begin : g_stage
        localparam vcode_t TRIP  = vcode_t'((g == 0) ? UP_MV : LO_MV);
        localparam vcode_t CLEAR = vcode_t'(((g == 0) ? UP_MV : LO_MV) + HYST_MV);

        always_ff @(posedge clk) begin
            if (por_i) flag_q[g] <= 1'b0;
            else       flag_q[g] <= hyst_next(flag_q[g], vcode_i, TRIP, MARGIN);
        end

        AST_TRIP_BELOW: assert property (@(posedge clk) disable iff (por_i)
            $rose(flag_q[g]) |-> $past(vcode_i) < TRIP); // R5, R6
        AST_CLEAR_ABOVE: assert property (@(posedge clk) disable iff (por_i)
            $fell(flag_q[g]) |-> $past(vcode_i) >= CLEAR); // R5, R6
    end

    assign flags_o.low_irq = flag_q[0];
    assign flags_o.low_rst = flag_q[1];

endmodule

// File: rtl/rstseq_wake.sv
module rstseq_wake #(
    parameter int unsigned WAKE_CLKS = 4096
) (
    input  logic clk,
    input  logic por_i,
    input  logic any_i,
    input  logic osc_ready_i,
    input  logic flash_done_i,
    output logic rst_q_o
);
    localparam int CW = $clog2(WAKE_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_CLKS);

    logic [CW-1:0] cnt_q;
    logic          rst_q;
    logic          cnt_full;

    assign cnt_full = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (por_i || any_i) begin
            cnt_q <= '0;
            rst_q <= 1'b1;
        end else begin
            if (!cnt_full) cnt_q <= cnt_q + 1'b1;
            if (cnt_full && osc_ready_i && flash_done_i) rst_q <= 1'b0;
        end
    end

    assign rst_q_o = rst_q;

    AST_HOLD_ON_REQ: assert property (@(posedge clk) disable iff (por_i)
        any_i |=> rst_q); // R2
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (por_i)
        any_i |=> (cnt_q == '0)); // R4
    AST_RELEASE_GATED: assert property (@(posedge clk) disable iff (por_i)
        $fell(rst_q) |-> $past(cnt_full && osc_ready_i && flash_done_i && !any_i)); // R3

endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
    import rstseq_pkg::*;
(
    input  logic            clk,
    input  logic            por_i,
    input  src_t            src_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] cause_o
);
    logic [NSRC-1:0] cause_q;

    always_ff @(posedge clk) begin
        if (por_i) cause_q <= src_i;
        else       cause_q <= (cause_q & ~clr_i) | src_i;
    end

    assign cause_o = cause_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        AST_CAUSE_SET: assert property (@(posedge clk) disable iff (por_i)
            src_i[i] |=> cause_q[i]); // R9
        AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (por_i)
            ($past(cause_q[i]) && !$past(clr_i[i])) |-> cause_q[i]); // R9
    end

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int unsigned WAKE_CLKS = 4096,
    parameter int unsigned UP_MV     = 2950,
    parameter int unsigned LO_MV     = 2650,
    parameter int unsigned HYST_MV   = 50,
    parameter int          AW        = 32,
    parameter logic [AW-1:0] BOOT_ADDR = '0
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              ext_rst_n_i,
    input  logic              wdt_req_i,
    input  logic [VCODE_W-1:0] vcode_i,
    input  logic              osc_ready_i,
    input  logic              flash_done_i,
    input  logic              lvi_en_i,
    input  logic [NSRC-1:0]   cause_clr_i,
    output logic              rst_o,
    output logic              lvi_irq_o,
    output logic              lv_status_o,
    output logic [NSRC-1:0]   cause_o,
    output logic [AW-1:0]     boot_addr_o
);
    logic    ext_req;
    logic    rst_q;
    vflags_t vflags;
    src_t    src;

    rstseq_sync u_sync (
        .clk     (clk),
        .por_i   (por_i),
        .pin_n_i (ext_rst_n_i),
        .req_o   (ext_req)
    );

    rstseq_vmon #(
        .UP_MV   (UP_MV),
        .LO_MV   (LO_MV),
        .HYST_MV (HYST_MV)
    ) u_vmon (
        .clk     (clk),
        .por_i   (por_i),
        .vcode_i (vcode_i),
        .flags_o (vflags)
    );

    always_comb begin
        src.por = por_i;
        src.ext = ext_req;
        src.wdt = wdt_req_i;
        src.bod = vflags.low_rst;
    end

    rstseq_wake #(
        .WAKE_CLKS (WAKE_CLKS)
    ) u_wake (
        .clk          (clk),
        .por_i        (por_i),
        .any_i        (any_src(src)),
        .osc_ready_i  (osc_ready_i),
        .flash_done_i (flash_done_i),
        .rst_q_o      (rst_q)
    );

    rstseq_cause u_cause (
        .clk     (clk),
        .por_i   (por_i),
        .src_i   (src),
        .clr_i   (cause_clr_i),
        .cause_o (cause_o)
    );

    // Pin request bypasses the register so assertion is immediate
    assign rst_o       = rst_q | ext_req;
    assign lv_status_o = vflags.low_irq;
    assign lvi_irq_o   = vflags.low_irq & lvi_en_i;
    assign boot_addr_o = BOOT_ADDR;

    AST_BOD_FORCES_RST: assert property (@(posedge clk) disable iff (por_i)
        vflags.low_rst |=> rst_o); // R5
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (por_i)
        lvi_irq_o |-> (lv_status_o && lvi_en_i)); // R7

endmodule

// File: tb/rstseq_top_bench.sv
module rstseq_top_bench;
    localparam int W = 40;

    logic        clk = 1'b0;
    logic        por, ext_n, wdt, osc, flash, en;
    logic [11:0] vcode;
    logic [3:0]  clr;
    logic        rst, irq, lvs;
    logic [3:0]  cause;
    logic [31:0] boot;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    rstseq_top #(.WAKE_CLKS(W)) u_rstseq_top (
        .clk(clk), .por_i(por), .ext_rst_n_i(ext_n), .wdt_req_i(wdt),
        .vcode_i(vcode), .osc_ready_i(osc), .flash_done_i(flash),
        .lvi_en_i(en), .cause_clr_i(clr), .rst_o(rst), .lvi_irq_o(irq),
        .lv_status_o(lvs), .cause_o(cause), .boot_addr_o(boot)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Expected release latencies in clocks (R1, R3)
    function automatic int lat_sync_src();
        return W + 1;
    endfunction
    function automatic int lat_pin();
        return W + 3;
    endfunction
    function automatic int lat_bod();
        return W + 2;
    endfunction

    function automatic logic hyst_model(input logic cur, input int v, input int trip);
        return cur ? (v < trip + 50) : (v < trip);
    endfunction

    // Counts negedges until rst_o is seen low
    task automatic count_release(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst && n < 4 * W);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        logic exp_flag;
        void'($urandom(32'd20240611));
        por = 1; ext_n = 1; wdt = 0; osc = 1; flash = 1; en = 0;
        vcode = 12'd3300; clr = 4'h0;
        repeat (4) @(negedge clk);
        chk("R2 reset held in power-on", rst, 1);
        chk("R9 cause after power-on", cause, 1);
        chk("R10 boot address", boot, 0);
        chk("R6 status after reset", lvs, 0);

        // R3: power-on release
        por = 0;
        count_release(n);
        chk("R3 power-on release latency", n, lat_sync_src());
        chk("R10 boot address after release", boot, 0);

        // R9: write-one clear
        clr = 4'hF; @(negedge clk); clr = 4'h0;
        chk("R9 cause cleared", cause, 0);

        // R1: asynchronous pin assertion
        ext_n = 0; #1;
        chk("R1 pin asserts without clock", rst, 1);
        repeat (3) @(negedge clk);
        ext_n = 1;
        count_release(n);
        chk("R1 pin release latency", n, lat_pin());
        chk("R9 cause pin bit", cause, 4'b0010);
        clr = 4'b0010; @(negedge clk); clr = 4'h0;

        // R4: restart on reasserted watchdog
        wdt = 1; @(negedge clk); wdt = 0;
        repeat (10) @(negedge clk);
        chk("R4 still in reset mid-count", rst, 1);
        wdt = 1; @(negedge clk); wdt = 0;
        count_release(n);
        chk("R4 full wait after restart", n, lat_sync_src());
        chk("R9 cause watchdog bit", cause, 4'b0100);

        // R9: clear refused while request active
        wdt = 1; clr = 4'b0100; @(negedge clk); clr = 4'h0;
        chk("R9 clear loses to active request", cause[2], 1);
        wdt = 0; count_release(n);
        clr = 4'hF; @(negedge clk); clr = 4'h0;

        // R8: oscillator late
        osc = 0; wdt = 1; @(negedge clk); wdt = 0;
        repeat (W + 10) @(negedge clk);
        chk("R8 held for oscillator", rst, 1);
        osc = 1;
        count_release(n);
        chk("R8 release after oscillator", n, 1);

        // R8: flash late
        flash = 0; wdt = 1; @(negedge clk); wdt = 0;
        repeat (W + 10) @(negedge clk);
        chk("R8 held for flash", rst, 1);
        flash = 1;
        count_release(n);
        chk("R8 release after flash", n, 1);

        // R5: brownout with hysteresis
        clr = 4'hF; @(negedge clk); clr = 4'h0;
        vcode = 12'd2600;
        repeat (2) @(negedge clk);
        chk("R5 brownout asserts reset", rst, 1);
        chk("R9 cause brownout bit", cause[3], 1);
        chk("R6 status during brownout", lvs, 1);
        vcode = 12'd2680;
        repeat (W + 10) @(negedge clk);
        chk("R5 held inside hysteresis", rst, 1);
        vcode = 12'd2710;
        count_release(n);
        chk("R5 release after recovery", n, lat_bod());

        // R6, R7: upper stage random sweep
        vcode = 12'd3300;
        repeat (2) @(negedge clk);
        exp_flag = 0;
        for (int i = 0; i < 400; i++) begin
            int v;
            case (i)
                10: v = 2950;
                11: v = 2949;
                12: v = 2999;
                13: v = 3000;
                default: v = 2700 + int'($urandom_range(500));
            endcase
            vcode = 12'(v);
            en = 1'($urandom_range(1));
            @(negedge clk);
            exp_flag = hyst_model(exp_flag, v, 2950);
            chk("R6 upper flag", lvs, exp_flag);
            chk("R7 masked interrupt", irq, exp_flag & en);
            if (i % 50 == 0) chk("R6 upper stage no reset", rst, 0);
        end
        vcode = 12'd3300; en = 0;
        repeat (2) @(negedge clk);

        // Random reset episodes
        for (int k = 0; k < 12; k++) begin
            int hold;
            logic use_pin;
            clr = 4'hF; @(negedge clk); clr = 4'h0;
            use_pin = 1'($urandom_range(1));
            hold = 1 + int'($urandom_range(4));
            if (use_pin) ext_n = 0; else wdt = 1;
            repeat (hold) @(negedge clk);
            ext_n = 1; wdt = 0;
            count_release(n);
            if (use_pin) begin
                chk("R1 random pin episode", n, lat_pin());
                chk("R9 random pin cause", cause, 4'b0010);
            end else begin
                chk("R3 random watchdog episode", n, lat_sync_src());
                chk("R9 random watchdog cause", cause, 4'b0100);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule